// File: doc/BRIEF.md
# Two-Subphase Bus Request Driver

This block drives the request phase of a double-pumped front-side bus whose wires are all active-low. An upstream agent hands it one request at a time through a valid/ready handshake. Each request carries a physical byte address (bits 35 down to 3), a 5-bit request type, and a second transaction-type word. The driver then places the request on the bus in two back-to-back slots, one slot per clock edge. In the first slot the address wires carry the address and the strobe is asserted. In the second slot the same address wires carry the transaction-type word.

Two parity wires go out in the same slot as the signals they protect. Each parity wire is computed on the wire levels, and it is high when an even number of its covered wires are low. The two parity wires swap their coverage groups between the first and the second slot.

An address-20 mask input clears address bit 20 before the address reaches the wires, which gives the wrap-around at the 1 MB boundary. Between requests every wire idles high. A new request may be accepted during the second slot of the previous one, so requests can follow one another with no idle slot.

Top module: `fsb_req_driver`

## Requirements
- R1: After reset, req_ready is 1 and every bus wire (bus_a_n, bus_req_n, bus_ads_n, bus_ap_n) is high.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both 1. In the next slot, bus_ads_n is 0, bus_a_n is the bitwise inverse of the (possibly masked) address, and bus_req_n is the inverse of req_type. bus_ads_n is low for exactly one slot per request.
- R3: In the slot after the strobe, bus_ads_n is 1, bus_a_n is the inverse of the req_xtype captured at acceptance, and bus_req_n still carries the inverse of the captured request type.
- R4: req_ready is 0 during the strobe slot and 1 again during the second slot. This allows a new request to be accepted at the edge that ends the second slot.
- R5: In the strobe slot, bus_ap_n[0] is high exactly when an even number of bus_a_n wires 35..24 (vector bits 32..21) are low. bus_ap_n[1] is high exactly when an even number of the wires in bus_a_n 23..3 (vector bits 20..0) and bus_req_n are low.
- R6: In the second slot the coverage swaps. bus_ap_n[1] covers bus_a_n wires 35..24, and bus_ap_n[0] covers bus_a_n wires 23..3 together with bus_req_n, with the same even-low-is-high rule.
- R7: When a20_mask is 1 at acceptance, address bit 20 (bus_a_n vector bit 17) is driven as logical 0, that is, the wire is high, in the strobe slot. When a20_mask is 0, that bit follows the address. The mask never alters the second-slot word.
- R8: In a slot that is neither a strobe slot nor a second slot, every bus wire is high.
- R9: Values on req_valid and the request inputs while req_ready is 0 are ignored. The second slot still shows the word captured at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one bus slot per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Upstream request present |
| req_ready | output | 1 | Driver can accept a request this edge |
| req_addr | input | 33 | Physical address bits 35..3 (vector bit i is address bit i+3) |
| req_type | input | 5 | Request type, logical polarity |
| req_xtype | input | 33 | Transaction-type word for the second slot |
| a20_mask | input | 1 | Clear address bit 20 of this request |
| bus_a_n | output | 33 | Active-low shared address wires 35..3 |
| bus_req_n | output | 5 | Active-low request wires |
| bus_ads_n | output | 1 | Active-low address strobe |
| bus_ap_n | output | 2 | Parity wires, computed on wire levels |

## Verification
Several properties are checked by assertions on every cycle: the single-slot strobe, ready being low under the strobe, the even-low parity rule in both slots with the swapped coverage, the cleared bit 20 after a masked acceptance, and all-high idle wires. Other behaviour only shows in the bench's scenarios. This covers whether the wires carry the right address, type and transaction word for each request, whether the mask leaves the second word and unmasked addresses alone, and whether stray inputs during the strobe slot leave the captured second-slot word intact when requests run back to back.

// File: rtl/fsb_req_pkg.sv
package fsb_req_pkg;

    localparam int DEF_ADDR_HI   = 35;
    localparam int DEF_ADDR_LO   = 3;
    localparam int DEF_REQ_W     = 5;
    localparam int DEF_PAR_SPLIT = 24;
    localparam int DEF_MASK_BIT  = 20;

    typedef enum logic [1:0] {
        SLOT_IDLE = 2'd0,
        SLOT_STB  = 2'd1,
        SLOT_TYPE = 2'd2
    } slot_e;

    typedef struct packed {
        logic strobe;
        logic swap;
    } slot_ctl_t;

    function automatic logic even_low(input logic odd_ones);
        return ~odd_ones;
    endfunction

endpackage

// File: rtl/fsb_a20_gate.sv
module fsb_a20_gate #(
    parameter int ADDR_LO  = 3,
    parameter int ADDR_W   = 33,
    parameter int MASK_BIT = 20
) (
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              gate_en,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int MIX = MASK_BIT - ADDR_LO;

    generate
        if (MIX >= 0 && MIX < ADDR_W) begin : g_gate
            always_comb begin
                addr_out = addr_in;
                if (gate_en) begin
                    addr_out[MIX] = 1'b0;
                end
            end
        end else begin : g_pass
            assign addr_out = addr_in;
        end
    endgenerate
endmodule

// File: rtl/fsb_par_gen.sv
module fsb_par_gen
    import fsb_req_pkg::*;
#(
    parameter int ADDR_W   = 33,
    parameter int REQ_W    = 5,
    parameter int SPLIT_IX = 21
) (
    input  logic [ADDR_W-1:0] a_log,
    input  logic [REQ_W-1:0]  rq_log,
    input  logic              swap,
    output logic [1:0]        ap_lvl
);
    logic hi_odd;
    logic lo_odd;

    // Logical ones are low wires, so odd ones means an odd low count.
    assign hi_odd = ^a_log[ADDR_W-1:SPLIT_IX];
    assign lo_odd = ^{a_log[SPLIT_IX-1:0], rq_log};

    generate
        for (genvar k = 0; k < 2; k++) begin : g_bit
            localparam bit HOME_HI = (k == 0);
            assign ap_lvl[k] = even_low((HOME_HI ^ swap) ? hi_odd : lo_odd);
        end
    endgenerate
endmodule

// File: rtl/fsb_slot_seq.sv
module fsb_slot_seq
    import fsb_req_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    output logic  in_ready,
    output logic  fire,
    output slot_e slot
);
    slot_e slot_nx;

    assign in_ready = (slot != SLOT_STB);
    assign fire     = in_valid && in_ready;

    always_comb begin
        slot_nx = slot;
        unique case (slot)
            SLOT_IDLE: slot_nx = fire ? SLOT_STB : SLOT_IDLE;
            SLOT_STB:  slot_nx = SLOT_TYPE;
            SLOT_TYPE: slot_nx = fire ? SLOT_STB : SLOT_IDLE;
            default:   slot_nx = SLOT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot <= SLOT_IDLE;
        end else begin
            slot <= slot_nx;
        end
    end

    assert_stb_then_type_R3: assert property (@(posedge clk) disable iff (rst)
        slot == SLOT_STB |=> slot == SLOT_TYPE);

    assert_fire_starts_R2: assert property (@(posedge clk) disable iff (rst)
        fire |=> slot == SLOT_STB);
endmodule

// File: rtl/fsb_req_driver.sv
module fsb_req_driver
    import fsb_req_pkg::*;
#(
    parameter int ADDR_HI   = DEF_ADDR_HI,
    parameter int ADDR_LO   = DEF_ADDR_LO,
    parameter int REQ_W     = DEF_REQ_W,
    parameter int PAR_SPLIT = DEF_PAR_SPLIT,
    parameter int MASK_BIT  = DEF_MASK_BIT,
    localparam int ADDR_W   = ADDR_HI - ADDR_LO + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [REQ_W-1:0]  req_type,
    input  logic [ADDR_W-1:0] req_xtype,
    input  logic              a20_mask,
    output logic [ADDR_W-1:0] bus_a_n,
    output logic [REQ_W-1:0]  bus_req_n,
    output logic              bus_ads_n,
    output logic [1:0]        bus_ap_n
);
    localparam int SPLIT_IX = PAR_SPLIT - ADDR_LO;
    localparam int MIX      = MASK_BIT - ADDR_LO;

    slot_e             slot;
    logic              fire;
    logic [ADDR_W-1:0] addr_gated;
    logic [ADDR_W-1:0] xtype_q;
    logic [REQ_W-1:0]  rtype_q;
    logic [ADDR_W-1:0] a_nx;
    logic [REQ_W-1:0]  rq_nx;
    slot_ctl_t         ctl_nx;
    logic [1:0]        ap_lvl;

    fsb_slot_seq i_seq (
        .clk      (clk),
        .rst      (rst),
        .in_valid (req_valid),
        .in_ready (req_ready),
        .fire     (fire),
        .slot     (slot)
    );

    fsb_a20_gate #(
        .ADDR_LO  (ADDR_LO),
        .ADDR_W   (ADDR_W),
        .MASK_BIT (MASK_BIT)
    ) i_gate (
        .addr_in  (req_addr),
        .gate_en  (a20_mask),
        .addr_out (addr_gated)
    );

    // Second-slot word, captured at acceptance.
    always_ff @(posedge clk) begin
        if (rst) begin
            xtype_q <= '0;
            rtype_q <= '0;
        end else if (fire) begin
            xtype_q <= req_xtype;
            rtype_q <= req_type;
        end
    end

    // Logical content of the next slot.
    always_comb begin
        a_nx   = '0;
        rq_nx  = '0;
        ctl_nx = '{strobe: 1'b0, swap: 1'b0};
        if (fire) begin
            a_nx   = addr_gated;
            rq_nx  = req_type;
            ctl_nx = '{strobe: 1'b1, swap: 1'b0};
        end else if (slot == SLOT_STB) begin
            a_nx   = xtype_q;
            rq_nx  = rtype_q;
            ctl_nx = '{strobe: 1'b0, swap: 1'b1};
        end
    end

    fsb_par_gen #(
        .ADDR_W   (ADDR_W),
        .REQ_W    (REQ_W),
        .SPLIT_IX (SPLIT_IX)
    ) i_par (
        .a_log  (a_nx),
        .rq_log (rq_nx),
        .swap   (ctl_nx.swap),
        .ap_lvl (ap_lvl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_a_n   <= '1;
            bus_req_n <= '1;
            bus_ads_n <= 1'b1;
            bus_ap_n  <= 2'b11;
        end else begin
            bus_a_n   <= ~a_nx;
            bus_req_n <= ~rq_nx;
            bus_ads_n <= ~ctl_nx.strobe;
            bus_ap_n  <= ap_lvl;
        end
    end

    assert_strobe_single_R2: assert property (@(posedge clk) disable iff (rst)
        !bus_ads_n |=> bus_ads_n);

    assert_ready_low_R4: assert property (@(posedge clk) disable iff (rst)
        !bus_ads_n |-> !req_ready);

    assert_par_first_R5: assert property (@(posedge clk) disable iff (rst)
        !bus_ads_n |->
            (bus_ap_n[0] == (($countones(~bus_a_n[ADDR_W-1:SPLIT_IX]) % 2) == 0)) &&
            (bus_ap_n[1] == ((($countones(~bus_a_n[SPLIT_IX-1:0]) +
                                $countones(~bus_req_n)) % 2) == 0)));

    assert_par_swap_R6: assert property (@(posedge clk) disable iff (rst)
        $past(!bus_ads_n) |->
            (bus_ap_n[1] == (($countones(~bus_a_n[ADDR_W-1:SPLIT_IX]) % 2) == 0)) &&
            (bus_ap_n[0] == ((($countones(~bus_a_n[SPLIT_IX-1:0]) +
                                $countones(~bus_req_n)) % 2) == 0)));

    generate
        if (MIX >= 0 && MIX < ADDR_W) begin : g_mask_chk
            assert_mask_clear_R7: assert property (@(posedge clk) disable iff (rst)
                $past(fire && a20_mask) |-> bus_a_n[MIX]);
        end
    endgenerate

    assert_idle_high_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_ads_n && $past(bus_ads_n)) |->
            ((&bus_a_n) && (&bus_req_n) && (&bus_ap_n)));
endmodule

// File: tb/test_fsb_req_driver.sv
module test_fsb_req_driver;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [32:0] req_addr = '0;
    logic [4:0]  req_type = '0;
    logic [32:0] req_xtype = '0;
    logic        a20_mask = 1'b0;
    logic [32:0] bus_a_n;
    logic [4:0]  bus_req_n;
    logic        bus_ads_n;
    logic [1:0]  bus_ap_n;

    int total = 0;
    int bad   = 0;
    bit in2   = 1'b0;
    bit armed = 1'b0;

    typedef struct {
        logic [32:0] a1;
        logic [4:0]  r1;
        logic [1:0]  p1;
        logic [32:0] a2;
        logic [1:0]  p2;
    } exp_t;

    exp_t sb[$];
    exp_t cur;

    always #4 clk = ~clk;

    fsb_req_driver i_fsb_req_driver (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .req_type  (req_type),
        .req_xtype (req_xtype),
        .a20_mask  (a20_mask),
        .bus_a_n   (bus_a_n),
        .bus_req_n (bus_req_n),
        .bus_ads_n (bus_ads_n),
        .bus_ap_n  (bus_ap_n)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic exp_t mk_exp(input logic [32:0] ad, input logic [4:0] ty,
                                    input logic [32:0] xt, input logic mk);
        exp_t e;
        logic [32:0] ag;
        ag = ad;
        if (mk) ag[17] = 1'b0;
        e.a1    = ~ag;
        e.r1    = ~ty;
        e.p1[0] = ($countones(ag[32:21]) % 2) == 0;
        e.p1[1] = (($countones(ag[20:0]) + $countones(ty)) % 2) == 0;
        e.a2    = ~xt;
        e.p2[1] = ($countones(xt[32:21]) % 2) == 0;
        e.p2[0] = (($countones(xt[20:0]) + $countones(ty)) % 2) == 0;
        return e;
    endfunction

    // Driver: stray inputs while not ready exercise R9.
    task automatic send(input logic [32:0] ad, input logic [4:0] ty,
                        input logic [32:0] xt, input logic mk);
        @(negedge clk);
        while (!req_ready) begin
            req_valid = 1'b1;
            req_addr  = ~ad;
            req_type  = ~ty;
            req_xtype = ~xt;
            a20_mask  = ~mk;
            @(negedge clk);
        end
        req_valid = 1'b1;
        req_addr  = ad;
        req_type  = ty;
        req_xtype = xt;
        a20_mask  = mk;
        sb.push_back(mk_exp(ad, ty, xt, mk));
    endtask

    task automatic pause(input int n);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: scoreboard compare of each slot.
    always @(negedge clk) begin
        if (armed && !rst) begin
            if (in2) begin
                chk("R3 R9 second-slot strobe", 64'(bus_ads_n), 64'd1);
                chk("R3 R9 second-slot word", 64'(bus_a_n), 64'(cur.a2));
                chk("R3 second-slot type", 64'(bus_req_n), 64'(cur.r1));
                chk("R6 swapped parity", 64'(bus_ap_n), 64'(cur.p2));
                chk("R4 ready in second slot", 64'(req_ready), 64'd1);
                in2 = 1'b0;
            end else if (!bus_ads_n) begin
                if (sb.size() == 0) begin
                    chk("R2 unexpected strobe", 64'(bus_ads_n), 64'd1);
                end else begin
                    cur = sb.pop_front();
                    chk("R2 R7 address wires", 64'(bus_a_n), 64'(cur.a1));
                    chk("R7 bit 20 wire", 64'(bus_a_n[17]), 64'(cur.a1[17]));
                    chk("R2 request wires", 64'(bus_req_n), 64'(cur.r1));
                    chk("R5 first-slot parity", 64'(bus_ap_n), 64'(cur.p1));
                    chk("R4 ready under strobe", 64'(req_ready), 64'd0);
                    in2 = 1'b1;
                end
            end else begin
                chk("R8 idle wires", {26'd0, bus_a_n, bus_req_n}, {26'd0, {38{1'b1}}});
                chk("R8 idle parity", 64'(bus_ap_n), 64'd3);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 ready after reset", 64'(req_ready), 64'd1);
        chk("R1 wires after reset", {25'd0, bus_a_n, bus_req_n, bus_ads_n},
            {25'd0, {39{1'b1}}});
        chk("R1 parity after reset", 64'(bus_ap_n), 64'd3);
        armed = 1'b1;

        send(33'd0, 5'd0, 33'd0, 1'b0);
        pause(2);
        send('1, 5'h1f, 33'd0, 1'b0);
        pause(2);
        send(33'h1 << 17, 5'h03, 33'h0_0000_0F0F, 1'b1);
        pause(1);
        send(33'h1 << 17, 5'h03, 33'h0_0000_0F0F, 1'b0);
        pause(1);
        send(33'h1_FFFF_FFFF, 5'h11, 33'h1 << 17, 1'b1);
        pause(2);
        for (int i = 0; i < 6; i++) begin
            send(33'h1_2345_6789 ^ (33'(i) << (i * 5)), 5'(i * 7 + 1),
                 33'h0_A5A5_5A5A + 33'(i * 3), 1'(i % 2));
        end
        pause(4);
        chk("R2 queue drained", 64'(sb.size()), 64'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule